// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 96 pins. Each per-pin feature (output enable, drive value, interrupt enable, interrupt polarity, interrupt type and interrupt status) is held in its own group of 32-bit registers. Each register covers 32 pins. Software reaches the groups through a simple 32-bit read/write port. Read data comes back registered, one clock after the address is presented.

Pin inputs pass through a two-stage synchroniser. Each pin then has its own event detector, which senses a level or an edge with a polarity chosen per pin. Detected events are latched into sticky status bits. Software clears a status bit by writing a one to it, normally after masking the pin. A single registered interrupt line reports whenever any pending bit is also enabled.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Pin n maps to bit (n mod 32) of the register at byte address FEATURE_BASE + 4*(n/32). Address bits [6:4] select the feature: 0 output enable, 1 drive, 2 interrupt enable, 3 polarity, 4 type, 5 status. Bits [3:2] select the bank. A written register reads back its value on bus_rdata in the cycle after the read address is applied.
- R2: An output-enable bit of 1 drives the matching pin_oe bit high, and a bit of 0 leaves the pin as an input.
- R3: A write to the drive group sets pin_out. A read of the drive group returns the synchronised level of pin_in.
- R4: A pin_in change applied just after a clock edge is first visible in a drive-group read on the third rising edge that follows.
- R5: With type bit 0 (level), a pin sets its status bit every cycle its synchronised level matches the polarity: polarity 0 means high, polarity 1 means low.
- R6: With type bit 1 (edge), a pin sets its status bit once per transition: polarity 0 means rising and polarity 1 means falling. A steady level or an opposite edge sets nothing.
- R7: Status bits are sticky. Writing 1 clears a bit and writing 0 has no effect. A level source that is still active keeps its bit set through a clear.
- R8: Status is latched whether or not the pin is enabled. irq is high in the cycle after any bit is set in both status and enable, and low in the cycle after none is.
- R9: Reset clears output enable, drive, enable, status, polarity and type (level, active-high), and drives irq low.
- R10: Bits at or above NUM_PINS, banks at or beyond the bank count, and unused feature codes read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 7 | Byte address: feature [6:4], bank [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Drive value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Aggregated registered interrupt |

## Verification
The hardest case to reach is an event that arrives while software is clearing it. A level source that is still active must survive a write-one clear. An edge source must not come back after a clear unless the pin really toggles again. The stimulus holds a level pin active through its clear and checks the bit stays set. It then clears an edge pin with its input held steady and checks the bit stays clear. Last, it drops the pin and raises it again to re-arm the edge, and only then opens the enable, so the irq line is seen to follow the enable and not the event.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int ADDR_W = 7;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FT_OE   = 3'd0,
    FT_DRV  = 3'd1,
    FT_IEN  = 3'd2,
    FT_POL  = 3'd3,
    FT_TYP  = 3'd4,
    FT_STAT = 3'd5
  } gic_feat_e;
endpackage

// File: rtl/gic_pin_sync.sv
module gic_pin_sync #(
  parameter int NUM_PINS = 96
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] sync_lvl,
  output logic [NUM_PINS-1:0] sync_prev
);
  logic [NUM_PINS-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q    <= '0;
      sync_lvl  <= '0;
      sync_prev <= '0;
    end else begin
      meta_q    <= pin_in;
      sync_lvl  <= meta_q;
      sync_prev <= sync_lvl;
    end
  end
endmodule

// File: rtl/gic_irq_detect.sv
module gic_irq_detect #(
  parameter int NUM_PINS = 96
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] sync_lvl,
  input  logic [NUM_PINS-1:0] sync_prev,
  input  logic [NUM_PINS-1:0] typ,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] ack,
  output logic [NUM_PINS-1:0] stat
);
  logic [NUM_PINS-1:0] lvl_hit, rise, fall, edge_hit, evt;

  // Level: active when synchronised level differs from the polarity bit
  assign lvl_hit  = ~typ & (sync_lvl ^ pol);
  assign rise     = sync_lvl & ~sync_prev;
  assign fall     = ~sync_lvl & sync_prev;
  assign edge_hit = typ & ((~pol & rise) | (pol & fall));
  assign evt      = lvl_hit | edge_hit;

  // New events take priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~ack) | evt;
  end

  // R5: an active-high level source is latched on the next edge
  a_r5_level_high: assert property (@(posedge clk) disable iff (rst)
    (($past(~typ & ~pol & sync_lvl) & ~stat) == '0));

  // R6: a rising edge on an edge-type, rising-polarity pin is latched
  a_r6_rise_latch: assert property (@(posedge clk) disable iff (rst)
    (($past(typ & ~pol & sync_lvl & ~sync_prev) & ~stat) == '0));

  // R7: a set bit only falls after a write-one clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(stat & ~ack) & ~stat) == '0));
endmodule

// File: rtl/gic_regfile.sv
module gic_regfile
  import gic_pkg::*;
#(
  parameter int NUM_PINS = 96
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] sync_lvl,
  input  logic [NUM_PINS-1:0] stat,
  output logic [NUM_PINS-1:0] oe,
  output logic [NUM_PINS-1:0] drv,
  output logic [NUM_PINS-1:0] ien,
  output logic [NUM_PINS-1:0] pol,
  output logic [NUM_PINS-1:0] typ,
  output logic [NUM_PINS-1:0] ack
);
  localparam int NBANK = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PADW  = NBANK * WORD_W;

  logic [2:0] feat;
  logic [1:0] bank;
  assign feat = bus_addr[6:4];
  assign bank = bus_addr[3:2];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [1:0] PBANK = 2'(p / WORD_W);
    localparam int         PBIT  = p % WORD_W;
    logic hit, wbit;
    assign hit  = bus_we && (bank == PBANK);
    assign wbit = bus_wdata[PBIT];

    always_ff @(posedge clk) begin
      if (rst) begin
        oe[p]  <= 1'b0;
        drv[p] <= 1'b0;
        ien[p] <= 1'b0;
        pol[p] <= 1'b0;
        typ[p] <= 1'b0;
      end else if (hit) begin
        case (feat)
          FT_OE:   oe[p]  <= wbit;
          FT_DRV:  drv[p] <= wbit;
          FT_IEN:  ien[p] <= wbit;
          FT_POL:  pol[p] <= wbit;
          FT_TYP:  typ[p] <= wbit;
          default: ;
        endcase
      end
    end

    assign ack[p] = hit && (feat == FT_STAT) && wbit;
  end

  function automatic logic [WORD_W-1:0] pick(input logic [NUM_PINS-1:0] v,
                                             input logic [1:0] b);
    logic [PADW-1:0] t;
    t = '0;
    t[NUM_PINS-1:0] = v;
    if (int'(b) < NBANK) pick = t[int'(b)*WORD_W +: WORD_W];
    else                 pick = '0;
  endfunction

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    case (feat)
      FT_OE:   rd_mux = pick(oe, bank);
      FT_DRV:  rd_mux = pick(sync_lvl, bank);
      FT_IEN:  rd_mux = pick(ien, bank);
      FT_POL:  rd_mux = pick(pol, bank);
      FT_TYP:  rd_mux = pick(typ, bank);
      FT_STAT: rd_mux = pick(stat, bank);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R10: an unimplemented bank or feature code reads as zero
  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ((int'(bus_addr[3:2]) >= NBANK) || (bus_addr[6:4] > 3'd5)) |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gic_pkg::*;
#(
  parameter int NUM_PINS = 96
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [6:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] sync_lvl, sync_prev;
  logic [NUM_PINS-1:0] oe, drv, ien, pol, typ, ack, stat;

  gic_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .sync_lvl(sync_lvl), .sync_prev(sync_prev)
  );

  gic_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .sync_lvl(sync_lvl), .sync_prev(sync_prev),
    .typ(typ), .pol(pol), .ack(ack), .stat(stat)
  );

  gic_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_lvl(sync_lvl),
    .stat(stat), .oe(oe), .drv(drv), .ien(ien), .pol(pol), .typ(typ),
    .ack(ack)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & ien);
  end

  assign pin_out = drv;
  assign pin_oe  = oe;

  // R8: no enabled pending bit means the line is low next cycle
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((stat & ien) == '0) |=> !irq);

  // R8: any enabled pending bit raises the line next cycle
  a_r8_irq_fires: assert property (@(posedge clk) disable iff (rst)
    ((stat & ien) != '0) |=> irq);
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int NP = 70;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP)) i_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed {
    logic [6:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  // Write then read back; expected value accounts for R10 holes
  localparam vec_t VT [7] = '{
    '{7'h00, 32'h8000_0001, 32'h8000_0001},
    '{7'h04, 32'h1234_5678, 32'h1234_5678},
    '{7'h08, 32'hFFFF_FFFF, 32'h0000_003F},
    '{7'h0C, 32'hFFFF_FFFF, 32'h0000_0000},
    '{7'h24, 32'h00F0_0F00, 32'h00F0_0F00},
    '{7'h48, 32'hFFFF_FFFF, 32'h0000_003F},
    '{7'h40, 32'hDEAD_BEEF, 32'hDEAD_BEEF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    pin_in = '0; bus_we = 1'b0; rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R9: reset state
    for (int f = 0; f < 6; f++) begin
      rd(7'(f << 4), d);
      chk("R9 reset reg", d, 32'h0);
    end
    chk("R9 irq low", {31'b0, irq}, 32'h0);
    chk("R9 pin_oe clear", pin_oe[31:0], 32'h0);

    // R1, R10: table walk
    for (int i = 0; i < 7; i++) begin
      wr(VT[i].a, VT[i].w);
      rd(VT[i].a, d);
      chk("R1/R10 readback", d, VT[i].e);
    end
    // R2: output enables reach the pins
    chk("R2 oe bank0", pin_oe[31:0], 32'h8000_0001);
    chk("R2 oe bank1", pin_oe[63:32], 32'h1234_5678);
    chk("R2 oe bank2", {26'b0, pin_oe[69:64]}, 32'h3F);

    do_reset();
    chk("R9 oe after reset", pin_oe[63:32], 32'h0);

    // R3: drive value and pin read
    wr(7'h10, 32'h0000_00FF);
    chk("R3 pin_out", pin_out[31:0], 32'h0000_00FF);
    pin_in[3] = 1'b1;
    tick(3);
    rd(7'h10, d);
    chk("R3 drive read is pin level", d, 32'h8);

    // R4: synchroniser latency
    bus_addr = 7'h10;
    pin_in[5] = 1'b1;
    tick(1);
    chk("R4 not yet edge1", {31'b0, bus_rdata[5]}, 32'h0);
    tick(1);
    chk("R4 not yet edge2", {31'b0, bus_rdata[5]}, 32'h0);
    tick(1);
    chk("R4 visible edge3", {31'b0, bus_rdata[5]}, 32'h1);

    do_reset();

    // R5: level high on pin 1
    wr(7'h20, 32'h2);
    pin_in[1] = 1'b1;
    tick(3);
    rd(7'h50, d);
    chk("R5 level high latched", d, 32'h2);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    // R7: clear while still active keeps the bit
    wr(7'h50, 32'h2);
    rd(7'h50, d);
    chk("R7 active level survives clear", d, 32'h2);
    pin_in[1] = 1'b0;
    tick(3);
    wr(7'h50, 32'h2);
    rd(7'h50, d);
    chk("R7 clear after release", d, 32'h0);
    tick(1);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R5: level low on pin 40
    wr(7'h34, 32'h100);
    tick(2);
    rd(7'h54, d);
    chk("R5 level low latched", d, 32'h100);
    wr(7'h34, 32'h0);
    wr(7'h54, 32'h100);
    rd(7'h54, d);
    chk("R7 low source cleared", d, 32'h0);

    // R6: rising edge on pin 66
    wr(7'h48, 32'h4);
    pin_in[66] = 1'b1;
    tick(3);
    rd(7'h58, d);
    chk("R6 rising latched", d, 32'h4);
    chk("R8 unenabled no irq", {31'b0, irq}, 32'h0);
    wr(7'h58, 32'h0);
    rd(7'h58, d);
    chk("R7 write zero no effect", d, 32'h4);
    wr(7'h58, 32'h4);
    tick(2);
    rd(7'h58, d);
    chk("R6 steady high no re-set", d, 32'h0);
    pin_in[66] = 1'b0;
    tick(3);
    rd(7'h58, d);
    chk("R6 falling ignored on rising pin", d, 32'h0);
    pin_in[66] = 1'b1;
    tick(3);
    chk("R8 pending but masked", {31'b0, irq}, 32'h0);
    wr(7'h28, 32'h4);
    tick(1);
    chk("R8 irq after enable", {31'b0, irq}, 32'h1);

    // R6: falling edge on pin 67
    wr(7'h48, 32'hC);
    wr(7'h38, 32'h8);
    pin_in[67] = 1'b1;
    tick(3);
    rd(7'h58, d);
    chk("R6 rise ignored on falling pin", d, 32'h4);
    pin_in[67] = 1'b0;
    tick(3);
    rd(7'h58, d);
    chk("R6 falling latched", d, 32'hC);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule